// File: doc/BRIEF.md
# PCI Clock-Run Stop/Restart Controller

This block takes the bridge's part in the open-drain clock-run handshake on a PCI bus. The central resource releases the clock-run line to announce that it wants to stop the PCI clock. The controller compares that request against six internal reasons to keep the clock alive. If any of them holds, it pulls the line low to refuse, drives it high for one clock, and then lets it go. If none holds, it stays silent and the clock may stop.

While the clock is allowed to stop, the controller watches four kinds of wake event on every card socket: card interrupts, status-change or ring events, a card trying to start its own card clock, and a card requesting the card bus. Any of them makes the controller pull the line low to ask for the clock back. All condition and event inputs pass through a two-flop synchroniser. A wake event seen while the clock is still running is held in a latch, so a stop granted afterwards is followed at once by a restart request.

The line is modelled as an output enable plus a driven value. The pad and the pull-up sit outside the block.

Top module: `clkrun_ctl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the line is not driven (`clkrun_oe` = 0).
- R2: When a stop request arrives and no keep condition holds, the line stays released, so the clock may stop. If the central resource later pulls the line low, the block returns to its running state and can refuse a later request.
- R3: While the keep-clock configuration bit is set, every stop request is refused.
- R4: While the 16-bit card resource manager reports busy, every stop request is refused.
- R5: While the CardBus master state machine reports busy or a cycle in progress, every stop request is refused.
- R6: While posted CardBus-to-PCI write data may be held, every stop request is refused.
- R7: While any interrupt is pending, every stop request is refused.
- R8: Unless every socket's bit in `cclk_stopped` is 1, every stop request is refused.
- R9: Refusal timing. The line is driven low (oe=1, o=0) from the second rising edge after the line first reads high. It stays low for one cycle, is driven high (oe=1, o=1) for one cycle, and is then released.
- R10: While stopped, a pulse on `card_irq` for any socket causes a restart request.
- R11: While stopped, a pulse on `card_stschg` for any socket causes a restart request.
- R12: While stopped, a pulse on `cclkrun_req` or `card_creq` for any socket causes a restart request.
- R13: Restart timing. The line is driven low from the third rising edge after a one-cycle event pulse. It stays low for RESTART_CLKS cycles (default 2), is driven high for one cycle, and is then released.
- R14: A wake event that pulses while the clock is running is remembered. When a later stop request is granted, the restart request follows on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| clkrun_n_in | input | 1 | Sampled level of the clock-run line (active low) |
| clkrun_oe | output | 1 | Output enable for the clock-run pad |
| clkrun_o | output | 1 | Value driven while `clkrun_oe` is 1 |
| keep_clk_cfg | input | 1 | Configuration bit: never let the clock stop |
| pc16_busy | input | 1 | 16-bit card resource manager busy |
| cb_master_busy | input | 1 | CardBus master busy or cycle in progress |
| posted_busy | input | 1 | Posted CardBus-to-PCI data pending |
| irq_pending | input | 1 | An interrupt is pending |
| cclk_stopped | input | NSOCK | Per socket: card clock already stopped |
| card_irq | input | NSOCK | Per socket: 16-bit IREQ or CardBus CINT |
| card_stschg | input | NSOCK | Per socket: status-change or ring event |
| cclkrun_req | input | NSOCK | Per socket: card asks to start its clock |
| card_creq | input | NSOCK | Per socket: card requests the card bus |

## Verification
On every cycle the assertions check the state-to-state shape of the handshake. A request is refused whenever a keep condition holds and granted otherwise. The line goes low, then high, then released, in fixed order. The line stays quiet while running or stopped, and a pending wake always moves the block from stopped to restarting. Only the directed scenarios show the end-to-end behaviour: each individual keep input and each wake-event kind on each socket reaching the pins through the synchronisers, the exact edge counts from release or event pulse to pin activity, and a wake event latched during running being serviced after a later grant.

// File: rtl/clkrun_pkg.sv
package clkrun_pkg;

    typedef enum logic [2:0] {
        CR_RUN     = 3'd0,
        CR_REFUSE  = 3'd1,
        CR_PRECHG  = 3'd2,
        CR_STOPPED = 3'd3,
        CR_WAKE    = 3'd4
    } cr_state_e;

    // Fixed keep-alive reasons; the socket clock term is folded in after sync
    typedef struct packed {
        logic cfg_keep;
        logic pc16_busy;
        logic cbm_busy;
        logic posted;
        logic irq;
        logic cclk_live;
    } keep_cond_t;

    localparam int KEEP_FIXED_W = 5;
    localparam int WAKE_KINDS   = 4;

    function automatic logic keep_any_f(input keep_cond_t k);
        return |k;
    endfunction

    function automatic logic drives_line(input cr_state_e s);
        return (s == CR_REFUSE) || (s == CR_PRECHG) || (s == CR_WAKE);
    endfunction

endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cr_wake_latch.sv
module cr_wake_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ev_sync,
    input  logic         clr,
    output logic         pend
);
    logic held;
    logic live;

    assign live = |ev_sync;

    always_ff @(posedge clk) begin
        if (rst)       held <= 1'b0;
        else if (clr)  held <= 1'b0;
        else if (live) held <= 1'b1;
    end

    assign pend = held | live;
endmodule

// File: rtl/cr_fsm.sv
module cr_fsm
    import clkrun_pkg::*;
#(
    parameter int RESTART_CLKS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_n,
    input  logic      keep_any,
    input  logic      wake_pend,
    output logic      oe,
    output logic      drv_val,
    output logic      stop_req,
    output logic      wake_clr,
    output cr_state_e state
);
    localparam int CNT_W = (RESTART_CLKS > 1) ? $clog2(RESTART_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_CLKS - 1);

    cr_state_e      st;
    logic           line_q;
    logic           own_q;
    logic           line_low;
    logic [CNT_W-1:0] cnt;

    // Ignore samples taken while this block was driving the line itself
    assign stop_req = line_q & ~own_q;
    assign line_low = ~line_q & ~own_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CR_RUN;
            line_q <= 1'b0;
            own_q  <= 1'b0;
            cnt    <= '0;
        end else begin
            line_q <= line_n;
            own_q  <= oe;
            unique case (st)
                CR_RUN: begin
                    if (stop_req) st <= keep_any ? CR_REFUSE : CR_STOPPED;
                end
                CR_REFUSE:  st <= CR_PRECHG;
                CR_PRECHG:  st <= CR_RUN;
                CR_STOPPED: begin
                    cnt <= '0;
                    if (line_low)       st <= CR_RUN;
                    else if (wake_pend) st <= CR_WAKE;
                end
                CR_WAKE: begin
                    if (cnt == CNT_LAST) st <= CR_PRECHG;
                    else                 cnt <= cnt + 1'b1;
                end
                default: st <= CR_RUN;
            endcase
        end
    end

    assign oe       = drives_line(st);
    assign drv_val  = (st == CR_PRECHG);
    assign wake_clr = ((st == CR_WAKE) && (cnt == CNT_LAST)) ||
                      ((st == CR_STOPPED) && line_low);
    assign state    = st;
endmodule

// File: rtl/clkrun_ctl.sv
module clkrun_ctl
    import clkrun_pkg::*;
#(
    parameter int NSOCK        = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int RESTART_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clkrun_n_in,
    output logic             clkrun_oe,
    output logic             clkrun_o,
    input  logic             keep_clk_cfg,
    input  logic             pc16_busy,
    input  logic             cb_master_busy,
    input  logic             posted_busy,
    input  logic             irq_pending,
    input  logic [NSOCK-1:0] cclk_stopped,
    input  logic [NSOCK-1:0] card_irq,
    input  logic [NSOCK-1:0] card_stschg,
    input  logic [NSOCK-1:0] cclkrun_req,
    input  logic [NSOCK-1:0] card_creq
);
    localparam int KW = KEEP_FIXED_W + NSOCK;
    localparam int WW = WAKE_KINDS * NSOCK;

    logic [KW-1:0] keep_raw, keep_s;
    logic [WW-1:0] wake_raw, wake_s;
    keep_cond_t    kc;
    logic          keep_any;
    logic          wake_pend;
    logic          wake_clr;
    logic          stop_req;
    cr_state_e     state;

    assign keep_raw = {cclk_stopped, irq_pending, posted_busy,
                       cb_master_busy, pc16_busy, keep_clk_cfg};
    assign wake_raw = {card_creq, cclkrun_req, card_stschg, card_irq};

    cr_sync #(.W(KW), .STAGES(SYNC_STAGES)) u_keep_sync (
        .clk(clk), .rst(rst), .d(keep_raw), .q(keep_s)
    );

    cr_sync #(.W(WW), .STAGES(SYNC_STAGES)) u_wake_sync (
        .clk(clk), .rst(rst), .d(wake_raw), .q(wake_s)
    );

    always_comb begin
        kc.cfg_keep  = keep_s[0];
        kc.pc16_busy = keep_s[1];
        kc.cbm_busy  = keep_s[2];
        kc.posted    = keep_s[3];
        kc.irq       = keep_s[4];
        kc.cclk_live = ~&keep_s[KW-1:KEEP_FIXED_W];
    end

    assign keep_any = keep_any_f(kc);

    cr_wake_latch #(.W(WW)) u_wake (
        .clk(clk), .rst(rst), .ev_sync(wake_s), .clr(wake_clr), .pend(wake_pend)
    );

    cr_fsm #(.RESTART_CLKS(RESTART_CLKS)) u_fsm (
        .clk(clk), .rst(rst), .line_n(clkrun_n_in), .keep_any(keep_any),
        .wake_pend(wake_pend), .oe(clkrun_oe), .drv_val(clkrun_o),
        .stop_req(stop_req), .wake_clr(wake_clr), .state(state)
    );
endmodule

// File: rtl/clkrun_ctl_chk.sv
module clkrun_ctl_chk
    import clkrun_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      clkrun_oe,
    input logic      clkrun_o,
    input cr_state_e state,
    input logic      keep_any,
    input logic      wake_pend,
    input logic      stop_req
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (state == CR_RUN && !clkrun_oe)); // R1

    AST_GRANT_STOP: assert property (@(posedge clk) disable iff (rst)
        (state == CR_RUN && stop_req && !keep_any) |=> state == CR_STOPPED); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == CR_RUN || state == CR_STOPPED) |-> !clkrun_oe); // R2

    AST_KEEP_REFUSES: assert property (@(posedge clk) disable iff (rst)
        (state == CR_RUN && stop_req && keep_any) |=> state == CR_REFUSE); // R3

    AST_REFUSE_LOW: assert property (@(posedge clk) disable iff (rst)
        state == CR_REFUSE |-> (clkrun_oe && !clkrun_o)); // R9

    AST_REFUSE_THEN_HIGH: assert property (@(posedge clk) disable iff (rst)
        state == CR_REFUSE |=> (state == CR_PRECHG && clkrun_oe && clkrun_o)); // R9

    AST_HIGH_THEN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        state == CR_PRECHG |=> !clkrun_oe); // R9

    AST_WAKE_GO: assert property (@(posedge clk) disable iff (rst)
        (state == CR_STOPPED && wake_pend && stop_req) |=> state == CR_WAKE); // R10

    AST_WAKE_LOW: assert property (@(posedge clk) disable iff (rst)
        state == CR_WAKE |-> (clkrun_oe && !clkrun_o)); // R13
endmodule

bind clkrun_ctl clkrun_ctl_chk u_chk (
    .clk(clk), .rst(rst), .clkrun_oe(clkrun_oe), .clkrun_o(clkrun_o),
    .state(state), .keep_any(keep_any), .wake_pend(wake_pend),
    .stop_req(stop_req)
);

// File: tb/sim_clkrun_ctl.sv
module sim_clkrun_ctl;
    localparam int CLK_P = 10;
    localparam int NS    = 2;
    localparam int REL   = 0;   // line released
    localparam int LOW   = 2;   // driven low
    localparam int HIGH  = 3;   // driven high

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cr_low = 1'b1;        // central resource pulling the line low
    logic keep_cfg = 0, pc16 = 0, cbm = 0, posted = 0, irqp = 0;
    logic [NS-1:0] cstop = '1, cirq = '0, cstsc = '0, ccrun = '0, ccreq = '0;
    logic oe, o;
    wire  line = oe ? o : ~cr_low;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    clkrun_ctl #(.NSOCK(NS)) u0 (
        .clk(clk), .rst(rst), .clkrun_n_in(line), .clkrun_oe(oe), .clkrun_o(o),
        .keep_clk_cfg(keep_cfg), .pc16_busy(pc16), .cb_master_busy(cbm),
        .posted_busy(posted), .irq_pending(irqp), .cclk_stopped(cstop),
        .card_irq(cirq), .card_stschg(cstsc), .cclkrun_req(ccrun), .card_creq(ccreq)
    );

    function automatic int pins();
        return oe ? (o ? HIGH : LOW) : REL;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; cr_low = 1'b1;
        @(negedge clk);
        chk("R1 during reset", pins(), REL);
        cyc(2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", pins(), REL);
        cyc(2);
    endtask

    // release the line and expect the refuse sequence
    task automatic t_refuse(input string req);
        cyc(3);
        cr_low = 1'b0;
        @(negedge clk);
        chk({req, " R9 quiet 1st edge"}, pins(), REL);
        @(negedge clk);
        chk({req, " refused"}, pins(), LOW);
        cr_low = 1'b1;
        @(negedge clk);
        chk({req, " R9 high"}, pins(), HIGH);
        @(negedge clk);
        chk({req, " R9 release"}, pins(), REL);
        cyc(3);
        chk({req, " R9 stays released"}, pins(), REL);
    endtask

    task automatic t_keep(input int which, input string req);
        case (which)
            0: keep_cfg = 1;
            1: pc16 = 1;
            2: cbm = 1;
            3: posted = 1;
            4: irqp = 1;
            5: cstop = 2'b01;
            default: cstop = 2'b10;
        endcase
        t_refuse(req);
        keep_cfg = 0; pc16 = 0; cbm = 0; posted = 0; irqp = 0; cstop = '1;
        cyc(3);
    endtask

    task automatic go_stopped(input string req);
        cyc(3);
        cr_low = 1'b0;
        cyc(2);
        chk({req, " R2 granted"}, pins(), REL);
        cyc(3);
        chk({req, " R2 still released"}, pins(), REL);
    endtask

    task automatic t_grant_and_return();
        go_stopped("grant");
        cr_low = 1'b1;          // central resource restarts the clock itself
        cyc(3);
        chk("R2 back to run", pins(), REL);
        keep_cfg = 1;
        t_refuse("R2 refuse after return");
        keep_cfg = 0;
        cyc(3);
    endtask

    task automatic t_wake(input int kind, input int sock, input string req);
        go_stopped(req);
        case (kind)
            0: cirq[sock]  = 1'b1;
            1: cstsc[sock] = 1'b1;
            2: ccrun[sock] = 1'b1;
            default: ccreq[sock] = 1'b1;
        endcase
        @(negedge clk);
        cirq = '0; cstsc = '0; ccrun = '0; ccreq = '0;
        @(negedge clk);
        chk({req, " R13 not yet"}, pins(), REL);
        @(negedge clk);
        chk({req, " wake low"}, pins(), LOW);
        cr_low = 1'b1;
        @(negedge clk);
        chk({req, " R13 low 2nd"}, pins(), LOW);
        @(negedge clk);
        chk({req, " R13 high"}, pins(), HIGH);
        @(negedge clk);
        chk({req, " R13 release"}, pins(), REL);
        cyc(3);
    endtask

    task automatic t_latched();
        cyc(2);
        ccreq[1] = 1'b1;
        @(negedge clk);
        ccreq = '0;
        cyc(5);
        chk("R14 no drive while running", pins(), REL);
        cr_low = 1'b0;
        cyc(2);
        chk("R14 granted", pins(), REL);
        @(negedge clk);
        chk("R14 immediate wake", pins(), LOW);
        cr_low = 1'b1;
        cyc(2);
        chk("R14 high", pins(), HIGH);
        @(negedge clk);
        chk("R14 release", pins(), REL);
        cyc(3);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_grant_and_return();
        t_keep(0, "R3 cfg");
        t_keep(1, "R4 pc16");
        t_keep(2, "R5 cbm");
        t_keep(3, "R6 posted");
        t_keep(4, "R7 irq");
        t_keep(5, "R8 sock1 live");
        t_keep(6, "R8 sock0 live");
        t_wake(0, 0, "R10 irq s0");
        t_wake(0, 1, "R10 irq s1");
        t_wake(1, 1, "R11 stschg s1");
        t_wake(1, 0, "R11 stschg s0");
        t_wake(2, 0, "R12 cclkrun s0");
        t_wake(3, 1, "R12 creq s1");
        t_latched();
        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule